// File: doc/BRIEF.md
# Serial Bit-Clock Source Auto-Selector

A single input pin on an audio receiver is used for one of two things. It can carry a running serial bit clock from an outside source, or it can be held at a steady level that switches de-emphasis on or off. This block works out which of the two the pin is doing at any time. It brings the shared pin and the frame sync into the master-clock domain, and it counts rising edges on the pin within each half of the frame. It moves between an internal-clock mode and an external-clock mode. Every mode change waits for a frame-sync transition, so a data word is never shifted with two different bit clocks.

The data shifter reads `bit_tick_o`, a one-cycle enable for each bit. In internal mode this enable comes from the local divider tick. In external mode it comes from the rising edges detected on the pin. The de-emphasis filter reads `deemph_en_o`. This output follows the pin level only while the block is in internal mode, and it is held low while an external clock is present. Both the edge-count threshold and the inactivity window are parameters.

Top module: `sclk_mode_select`

## Requirements
- R1: External mode is entered at a frame-sync transition (either direction) when at least EDGE_THRESH (default 16) rising edges of the shared pin were detected since the previous frame-sync transition; the edge count restarts at every frame-sync transition.
- R2: Edges split across two frame-sync halves never add up. With 15 edges in one half, or 8 in each of two halves, the block stays in internal mode.
- R3: In external mode, the block returns to internal mode at the (IDLE_FRAMES+1)-th frame-sync rising edge after the last pin rising edge, which means after IDLE_FRAMES (default 2) complete frames with no pin edge. Any pin rising edge restarts this window.
- R4: In external mode, `deemph_en_o` is 0 whatever the pin level.
- R5: In internal mode, `deemph_en_o` equals the synchronised pin level (1 = de-emphasis on).
- R6: `ext_mode_o` changes only in the cycle after a frame-sync transition is detected, never in the middle of a half.
- R7: In internal mode, `bit_tick_o` equals `int_tick_i`. In external mode, `bit_tick_o` gives one pulse for each pin rising edge, and `int_tick_i` has no effect.
- R8: While `rst_n` is low and right after it is released, `ext_mode_o` is 0 (internal mode), and the synchroniser registers are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_pin_i | input | 1 | Shared pin: external bit clock or de-emphasis level, asynchronous |
| frame_sync_i | input | 1 | Frame sync (left/right select), asynchronous |
| int_tick_i | input | 1 | Bit enable from the internal divider |
| ext_mode_o | output | 1 | 1 = external bit clock in use |
| deemph_en_o | output | 1 | De-emphasis enable, gated by mode |
| bit_tick_o | output | 1 | Selected one-cycle bit enable for the shifter |

## Verification
Four rules are checked on every clock cycle. The mode may only move right after a frame-sync transition. Entry needs a full edge count and exit needs an expired inactivity window. De-emphasis is forced off in external mode. The divider tick has no way through to the output once the external clock is selected. Only the bench scenarios can show the counting boundaries: 15 edges against 16, edges split across halves, entry from a falling half, exit after exactly two idle frames, and the tick counts seen in each mode.

// File: rtl/sms_pkg.sv
package sms_pkg;
   typedef enum logic {
      CLK_SRC_INT = 1'b0,
      CLK_SRC_EXT = 1'b1
   } clk_src_e;
endpackage

// File: rtl/sms_sync.sv
// Brings an asynchronous level into the clock domain and makes a one-cycle
// pulse, either on rising edges only or on both edges.
module sms_sync #(
   parameter int STAGES   = 2,
   parameter bit ANY_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic pulse_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sms_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];

   if (ANY_EDGE) begin : g_toggle
      assign pulse_o = level_o ^ prev_q;
   end else begin : g_rise
      assign pulse_o = level_o & ~prev_q;
   end
endmodule

// File: rtl/sms_edge_count.sv
// Counts pin edges within one frame-sync half and holds at the limit.
module sms_edge_count #(
   parameter int THRESH = 16,
   localparam int CW    = $clog2(THRESH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          inc_i,
   output logic [CW-1:0] cnt_o,
   output logic          full_o
);
   if (THRESH < 1) begin : g_bad_thresh
      $error("sms_edge_count: THRESH must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != CW'(THRESH))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign full_o = (cnt_q == CW'(THRESH));
endmodule

// File: rtl/sms_idle_timer.sv
// Counts frame-sync rising edges since the last pin edge. It reports expiry on
// the edge that would go past FRAMES.
module sms_idle_timer #(
   parameter int FRAMES = 2,
   localparam int IW    = $clog2(FRAMES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_i,
   input  logic          activity_i,
   output logic [IW-1:0] cnt_o,
   output logic          expire_o
);
   if (FRAMES < 1) begin : g_bad_frames
      $error("sms_idle_timer: FRAMES must be at least 1");
   end

   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (activity_i) begin
         cnt_q <= '0;
      end else if (frame_i && (cnt_q != IW'(FRAMES))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign expire_o = frame_i & ~activity_i & (cnt_q == IW'(FRAMES));
endmodule

// File: rtl/sclk_mode_select.sv
module sclk_mode_select
   import sms_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int EDGE_THRESH = 16,
   parameter int IDLE_FRAMES = 2,
   localparam int CW = $clog2(EDGE_THRESH + 1),
   localparam int IW = $clog2(IDLE_FRAMES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dual_pin_i,
   input  logic frame_sync_i,
   input  logic int_tick_i,
   output logic ext_mode_o,
   output logic deemph_en_o,
   output logic bit_tick_o
);
   logic          pin_lvl;
   logic          pin_rise;
   logic          fs_lvl;
   logic          fs_edge;
   logic          fs_rise;
   logic [CW-1:0] edge_cnt;
   logic          cnt_full;
   logic [IW-1:0] idle_cnt;
   logic          idle_expire;
   clk_src_e      src_q;

   sms_sync #(.STAGES(SYNC_STAGES), .ANY_EDGE(1'b0)) u_pin_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (dual_pin_i),
      .level_o (pin_lvl),
      .pulse_o (pin_rise)
   );

   sms_sync #(.STAGES(SYNC_STAGES), .ANY_EDGE(1'b1)) u_fs_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (frame_sync_i),
      .level_o (fs_lvl),
      .pulse_o (fs_edge)
   );

   assign fs_rise = fs_edge & fs_lvl;

   sms_edge_count #(.THRESH(EDGE_THRESH)) u_edge_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (fs_edge),
      .inc_i   (pin_rise),
      .cnt_o   (edge_cnt),
      .full_o  (cnt_full)
   );

   sms_idle_timer #(.FRAMES(IDLE_FRAMES)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_i    (fs_rise),
      .activity_i (pin_rise),
      .cnt_o      (idle_cnt),
      .expire_o   (idle_expire)
   );

   // The source only changes on a frame-sync transition. Entry takes priority.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= CLK_SRC_INT;
      end else if (fs_edge && cnt_full) begin
         src_q <= CLK_SRC_EXT;
      end else if ((src_q == CLK_SRC_EXT) && idle_expire) begin
         src_q <= CLK_SRC_INT;
      end
   end

   assign ext_mode_o  = (src_q == CLK_SRC_EXT);
   assign deemph_en_o = (src_q == CLK_SRC_INT) & pin_lvl;
   assign bit_tick_o  = (src_q == CLK_SRC_EXT) ? pin_rise : int_tick_i;
endmodule

// File: rtl/sms_checker.sv
module sms_checker #(
   parameter int EDGE_THRESH = 16,
   parameter int IDLE_FRAMES = 2,
   localparam int CW = $clog2(EDGE_THRESH + 1),
   localparam int IW = $clog2(IDLE_FRAMES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ext_mode_o,
   input logic          deemph_en_o,
   input logic          bit_tick_o,
   input logic          int_tick_i,
   input logic          pin_rise,
   input logic          fs_edge,
   input logic          cnt_full,
   input logic [CW-1:0] edge_cnt,
   input logic [IW-1:0] idle_cnt
);
   p_mode_at_frame_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ext_mode_o) |-> $past(fs_edge));

   p_entry_needs_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_mode_o) |-> $past(cnt_full));

   p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= CW'(EDGE_THRESH));

   p_exit_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_mode_o) |-> ($past(idle_cnt) == IW'(IDLE_FRAMES)));

   p_deemph_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode_o |-> !deemph_en_o);

   p_int_tick_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode_o && int_tick_i && !pin_rise) |-> !bit_tick_o);
endmodule

bind sclk_mode_select sms_checker #(
   .EDGE_THRESH (EDGE_THRESH),
   .IDLE_FRAMES (IDLE_FRAMES)
) u_sms_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_mode_o  (ext_mode_o),
   .deemph_en_o (deemph_en_o),
   .bit_tick_o  (bit_tick_o),
   .int_tick_i  (int_tick_i),
   .pin_rise    (pin_rise),
   .fs_edge     (fs_edge),
   .cnt_full    (cnt_full),
   .edge_cnt    (edge_cnt),
   .idle_cnt    (idle_cnt)
);

// File: tb/sclk_mode_select_test.sv
module sclk_mode_select_test;
   localparam int HALF = 80;
   localparam int NVEC = 22;

   // Fields: [7:3] pin pulses in this half, [2] pin level after the pulses,
   // [1] expected ext_mode_o at the end of the half, [0] expected deemph_en_o.
   localparam logic [7:0] VEC [NVEC] = '{
      {5'd0,  1'b1, 1'b0, 1'b1},
      {5'd0,  1'b0, 1'b0, 1'b0},
      {5'd15, 1'b0, 1'b0, 1'b0},
      {5'd0,  1'b0, 1'b0, 1'b0},
      {5'd8,  1'b0, 1'b0, 1'b0},
      {5'd8,  1'b0, 1'b0, 1'b0},
      {5'd16, 1'b0, 1'b0, 1'b0},
      {5'd16, 1'b0, 1'b1, 1'b0},
      {5'd16, 1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b1, 1'b0},
      {5'd0,  1'b0, 1'b0, 1'b0},
      {5'd16, 1'b1, 1'b0, 1'b1},
      {5'd0,  1'b1, 1'b1, 1'b0},
      {5'd0,  1'b1, 1'b1, 1'b0},
      {5'd0,  1'b1, 1'b1, 1'b0},
      {5'd0,  1'b1, 1'b1, 1'b0},
      {5'd0,  1'b1, 1'b0, 1'b1},
      {5'd0,  1'b1, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dual_pin = 1'b0;
   logic frame_sync = 1'b0;
   logic int_tick = 1'b0;
   logic ext_mode, deemph_en, bit_tick;
   logic fs_lvl = 1'b0;
   int   checks = 0;
   int   fails = 0;
   int   ticks = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   sclk_mode_select uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .dual_pin_i   (dual_pin),
      .frame_sync_i (frame_sync),
      .int_tick_i   (int_tick),
      .ext_mode_o   (ext_mode),
      .deemph_en_o  (deemph_en),
      .bit_tick_o   (bit_tick)
   );

   task automatic cyc();
      @(negedge clk);
      if (bit_tick) ticks++;
   endtask

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic play_half(input int npulse, input logic lvl, input logic itk);
      fs_lvl     = ~fs_lvl;
      frame_sync = fs_lvl;
      int_tick   = itk;
      ticks      = 0;
      dual_pin   = (npulse > 0) ? 1'b0 : lvl;
      repeat (8) cyc();
      for (int p = 0; p < npulse; p++) begin
         dual_pin = 1'b1;
         cyc();
         cyc();
         dual_pin = 1'b0;
         cyc();
         cyc();
      end
      dual_pin = lvl;
      repeat (HALF - 8 - 4 * npulse) cyc();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (4) cyc();
      chk("R8 ext_mode in reset", int'(ext_mode), 0);
      chk("R8 deemph in reset", int'(deemph_en), 0);
      chk("R8 bit_tick in reset", int'(bit_tick), 0);
      rst_n = 1'b1;
      repeat (4) cyc();

      // Table: R1 R2 R3 R4 R5 R6 covered by the expected columns
      for (int i = 0; i < NVEC; i++) begin
         play_half(int'(VEC[i][7:3]), VEC[i][2], 1'b0);
         chk($sformatf("vec %0d mode (R1 R2 R3 R6)", i), int'(ext_mode), int'(VEC[i][1]));
         chk($sformatf("vec %0d deemph (R4 R5)", i), int'(deemph_en), int'(VEC[i][0]));
      end

      // R7: internal tick passes straight through in internal mode
      int_tick = 1'b1;
      ticks = 0;
      repeat (10) cyc();
      int_tick = 1'b0;
      chk("R7 internal ticks", ticks, 10);

      // R7 and R1: after entry, only pin edges tick even with int_tick held high
      play_half(16, 1'b0, 1'b0);
      chk("R6 no entry mid-half", int'(ext_mode), 0);
      play_half(16, 1'b0, 1'b1);
      play_half(16, 1'b0, 1'b1);
      chk("R1 ext mode entered", int'(ext_mode), 1);
      chk("R7 external ticks", ticks, 16);
      int_tick = 1'b0;

      // R8: reset in external mode goes back to internal mode
      dual_pin = 1'b1;
      rst_n = 1'b0;
      cyc();
      chk("R8 ext_mode during reset", int'(ext_mode), 0);
      chk("R8 deemph during reset", int'(deemph_en), 0);
      rst_n = 1'b1;
      repeat (6) cyc();
      chk("R8 ext_mode after reset", int'(ext_mode), 0);
      chk("R5 deemph follows pin after reset", int'(deemph_en), 1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule